// File: doc/BRIEF.md
# Control Register Mode Manager

This block keeps the paging and mode control registers of a processor core: a machine control word (CR0), the page table base (CR3), the paging feature word (CR4) and the extended feature word (EFER). An execution unit writes one of them per cycle through a strobe, a two-bit select and a data word. The block applies the write and derives the hidden mode flags that the rest of the core reads every cycle: protected mode, long mode active, 64-bit code segment, and copies of the floating-point control bits.

Because some writes change the meaning of every cached translation, the block classifies each write. A write that alters paging structure raises a full flush of the translation cache. A new page table base while paging is on raises a lighter flush that keeps global entries. A write that switches paging on with long mode enabled enters long mode. If physical address extension is off at that moment, the whole write is refused. A write that switches paging off while in long mode leaves it and asks the fetch unit to cut the instruction pointer to 32 bits. All pulses are registered and last one cycle.

Top module: `crmode_mgr`

## Requirements
- R1: After reset CR0 reads 0x10, CR3, CR4 and EFER read zero, and every hidden flag and pulse output is low.
- R2: A CR0 write stores the written value with bit 4 (ET) forced to 1.
- R3: The pe, mp, em and ts outputs follow CR0 bits 0, 1, 2 and 3 of the stored value.
- R4: A CR0 write that takes bit 31 (PG) from 0 to 1 while EFER bit 8 (LME) and CR4 bit 5 (PAE) are set sets EFER bit 10 (LMA) and the lma output.
- R5: A CR0 write that would enter long mode while CR4 bit 5 is clear leaves CR0 and EFER unchanged.
- R6: A CR0 write that takes bit 31 from 1 to 0 while EFER bit 10 is set clears EFER bit 10, lma and cs64, and pulses ip_trunc for one cycle.
- R7: A CR0 write whose value differs from the stored one in bit 31, 16 (WP) or 0 (PE) pulses flush_all one cycle later, even if the write is refused under R5.
- R8: A CR3 write pulses flush_keep_global one cycle later when stored CR0 bit 31 is set, and raises no flush when it is clear.
- R9: A CR4 write stores the value and pulses flush_all when it changes bit 4 (PSE), 5 (PAE) or 7 (PGE); a change only in other bits raises no flush.
- R10: An EFER write stores all bits except bit 10, which keeps its previous value.
- R11: A cs64 load (cs64_wr) takes cs64_val only while EFER bit 10 is set; otherwise cs64 stays 0.
- R12: flush_all, flush_keep_global and ip_trunc are low in any cycle that does not follow a write strobe.
- R13: wr_sel selects 0 = CR0, 1 = CR3, 2 = CR4, 3 = EFER; with wr_en low no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | DATA_W | Write value |
| cs64_wr | input | 1 | Load strobe for the 64-bit code flag |
| cs64_val | input | 1 | Value for the 64-bit code flag |
| cr0_o | output | DATA_W | Stored CR0 |
| cr3_o | output | DATA_W | Stored CR3 |
| cr4_o | output | DATA_W | Stored CR4 |
| efer_o | output | DATA_W | Stored EFER |
| pe_o | output | 1 | Protected mode flag |
| mp_o | output | 1 | Monitor coprocessor flag |
| em_o | output | 1 | Emulate coprocessor flag |
| ts_o | output | 1 | Task switched flag |
| lma_o | output | 1 | Long mode active flag |
| cs64_o | output | 1 | 64-bit code segment flag |
| flush_all_o | output | 1 | Full translation flush pulse |
| flush_keep_global_o | output | 1 | Flush pulse that keeps global entries |
| ip_trunc_o | output | 1 | Instruction pointer truncate pulse |

## Verification
The bench builds the block with its defaults, DATA_W of 64 and long mode support enabled, so the entry, refusal and exit paths and the cs64 gating are all reachable. Random writes with random select and data exercise every paging bit combination, including entry attempts with PAE both set and clear. Directed sequences pin down refused entry, exit with its truncate pulse, the read-only LMA bit and CR3 writes with paging on and off.

// File: rtl/crmode_pkg.sv
package crmode_pkg;
   typedef enum logic [1:0] {
      SEL_CR0  = 2'd0,
      SEL_CR3  = 2'd1,
      SEL_CR4  = 2'd2,
      SEL_EFER = 2'd3
   } crsel_e;

   // bit positions decoded by software and the rest of the core
   localparam int B_PE  = 0;
   localparam int B_MP  = 1;
   localparam int B_EM  = 2;
   localparam int B_TS  = 3;
   localparam int B_ET  = 4;
   localparam int B_WP  = 16;
   localparam int B_PG  = 31;
   localparam int B_PSE = 4;
   localparam int B_PAE = 5;
   localparam int B_PGE = 7;
   localparam int B_LME = 8;
   localparam int B_LMA = 10;
endpackage

// File: rtl/crm_mode_ctl.sv
module crm_mode_ctl
   import crmode_pkg::*;
#(
   parameter bit LONG_MODE_EN = 1'b1
) (
   input  logic wr_cr0,
   input  logic new_pg,
   input  logic cur_pg,
   input  logic cur_lme,
   input  logic cur_lma,
   input  logic cur_pae,
   output logic cr0_accept,
   output logic lma_set,
   output logic lma_clr
);
   generate
      if (LONG_MODE_EN) begin : g_lm
         logic enter_req;
         assign enter_req  = wr_cr0 && !cur_pg && new_pg && cur_lme;
         assign lma_set    = enter_req && cur_pae;
         assign lma_clr    = wr_cr0 && cur_pg && !new_pg && cur_lma;
         assign cr0_accept = wr_cr0 && !(enter_req && !cur_pae);
      end else begin : g_nolm
         logic unused_lm;
         assign unused_lm  = ^{new_pg, cur_pg, cur_lme, cur_lma, cur_pae};
         assign lma_set    = 1'b0;
         assign lma_clr    = 1'b0;
         assign cr0_accept = wr_cr0;
      end
   endgenerate
endmodule

// File: rtl/crm_state_regs.sv
module crm_state_regs
   import crmode_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter bit LONG_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cr0_accept,
   input  logic              lma_set,
   input  logic              lma_clr,
   input  logic              cs64_wr,
   input  logic              cs64_val,
   output logic [DATA_W-1:0] cr0_q,
   output logic [DATA_W-1:0] cr3_q,
   output logic [DATA_W-1:0] cr4_q,
   output logic [DATA_W-1:0] efer_q,
   output logic              cs64_q
);
   localparam logic [DATA_W-1:0] ET_M    = DATA_W'(1) << B_ET;
   localparam logic [DATA_W-1:0] LMA_M   = DATA_W'(1) << B_LMA;
   localparam logic [DATA_W-1:0] CR0_RST = ET_M;

   logic [DATA_W-1:0] efer_wr_val;
   logic [DATA_W-1:0] efer_nx;
   logic              lma_now;

   assign lma_now     = efer_q[B_LMA];
   assign efer_wr_val = (wr_data & ~LMA_M) | (efer_q & LMA_M);

   always_comb begin
      efer_nx = efer_q;
      if (wr_en && crsel_e'(wr_sel) == SEL_EFER) efer_nx = efer_wr_val;
      if (lma_set) efer_nx = efer_nx | LMA_M;
      if (lma_clr) efer_nx = efer_nx & ~LMA_M;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr0_q  <= CR0_RST;
         cr3_q  <= '0;
         cr4_q  <= '0;
         efer_q <= '0;
      end else begin
         if (cr0_accept) cr0_q <= wr_data | ET_M;
         if (wr_en && crsel_e'(wr_sel) == SEL_CR3) cr3_q <= wr_data;
         if (wr_en && crsel_e'(wr_sel) == SEL_CR4) cr4_q <= wr_data;
         efer_q <= efer_nx;
      end
   end

   generate
      if (LONG_MODE_EN) begin : g_cs
         always_ff @(posedge clk) begin
            if (!rst_n)                  cs64_q <= 1'b0;
            else if (lma_clr)            cs64_q <= 1'b0;
            else if (cs64_wr && lma_now) cs64_q <= cs64_val;
         end
      end else begin : g_nocs
         logic unused_cs;
         assign unused_cs = ^{cs64_wr, cs64_val, lma_now};
         assign cs64_q    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/crm_flush_cls.sv
module crm_flush_cls
   import crmode_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] cr0_q,
   input  logic [DATA_W-1:0] cr4_q,
   input  logic              lma_clr,
   output logic              flush_all,
   output logic              flush_keep_global,
   output logic              ip_trunc
);
   localparam logic [DATA_W-1:0] CR0_PAGING_M =
      (DATA_W'(1) << B_PG) | (DATA_W'(1) << B_WP) | (DATA_W'(1) << B_PE);
   localparam logic [DATA_W-1:0] CR4_PAGING_M =
      (DATA_W'(1) << B_PGE) | (DATA_W'(1) << B_PAE) | (DATA_W'(1) << B_PSE);

   logic cr0_hit, cr4_hit, cr3_hit;

   assign cr0_hit = wr_en && crsel_e'(wr_sel) == SEL_CR0 &&
                    ((wr_data ^ cr0_q) & CR0_PAGING_M) != '0;
   assign cr4_hit = wr_en && crsel_e'(wr_sel) == SEL_CR4 &&
                    ((wr_data ^ cr4_q) & CR4_PAGING_M) != '0;
   assign cr3_hit = wr_en && crsel_e'(wr_sel) == SEL_CR3 && cr0_q[B_PG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_all         <= 1'b0;
         flush_keep_global <= 1'b0;
         ip_trunc          <= 1'b0;
      end else begin
         flush_all         <= cr0_hit || cr4_hit;
         flush_keep_global <= cr3_hit;
         ip_trunc          <= lma_clr;
      end
   end
endmodule

// File: rtl/crmode_mgr.sv
module crmode_mgr
   import crmode_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter bit LONG_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cs64_wr,
   input  logic              cs64_val,
   output logic [DATA_W-1:0] cr0_o,
   output logic [DATA_W-1:0] cr3_o,
   output logic [DATA_W-1:0] cr4_o,
   output logic [DATA_W-1:0] efer_o,
   output logic              pe_o,
   output logic              mp_o,
   output logic              em_o,
   output logic              ts_o,
   output logic              lma_o,
   output logic              cs64_o,
   output logic              flush_all_o,
   output logic              flush_keep_global_o,
   output logic              ip_trunc_o
);
   generate
      if (DATA_W < 32) begin : g_bad_w
         $error("crmode_mgr: DATA_W must be at least 32");
      end
   endgenerate

   logic cr0_accept, lma_set, lma_clr, wr_cr0;

   assign wr_cr0 = wr_en && crsel_e'(wr_sel) == SEL_CR0;

   crm_mode_ctl #(.LONG_MODE_EN(LONG_MODE_EN)) u_mode (
      .wr_cr0    (wr_cr0),
      .new_pg    (wr_data[B_PG]),
      .cur_pg    (cr0_o[B_PG]),
      .cur_lme   (efer_o[B_LME]),
      .cur_lma   (efer_o[B_LMA]),
      .cur_pae   (cr4_o[B_PAE]),
      .cr0_accept(cr0_accept),
      .lma_set   (lma_set),
      .lma_clr   (lma_clr)
   );

   crm_state_regs #(.DATA_W(DATA_W), .LONG_MODE_EN(LONG_MODE_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .cr0_accept(cr0_accept),
      .lma_set   (lma_set),
      .lma_clr   (lma_clr),
      .cs64_wr   (cs64_wr),
      .cs64_val  (cs64_val),
      .cr0_q     (cr0_o),
      .cr3_q     (cr3_o),
      .cr4_q     (cr4_o),
      .efer_q    (efer_o),
      .cs64_q    (cs64_o)
   );

   crm_flush_cls #(.DATA_W(DATA_W)) u_flush (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr_en            (wr_en),
      .wr_sel           (wr_sel),
      .wr_data          (wr_data),
      .cr0_q            (cr0_o),
      .cr4_q            (cr4_o),
      .lma_clr          (lma_clr),
      .flush_all        (flush_all_o),
      .flush_keep_global(flush_keep_global_o),
      .ip_trunc         (ip_trunc_o)
   );

   assign pe_o  = cr0_o[B_PE];
   assign mp_o  = cr0_o[B_MP];
   assign em_o  = cr0_o[B_EM];
   assign ts_o  = cr0_o[B_TS];
   assign lma_o = efer_o[B_LMA];
endmodule

// File: rtl/crmode_chk.sv
module crmode_chk
   import crmode_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] cr0_o,
   input logic [DATA_W-1:0] cr4_o,
   input logic [DATA_W-1:0] efer_o,
   input logic              lma_o,
   input logic              cs64_o,
   input logic              flush_all_o,
   input logic              flush_keep_global_o,
   input logic              ip_trunc_o
);
   p_et_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cr0_o[B_ET]);

   p_entry_needs_pae_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lma_o) |-> cr4_o[B_PAE] && cr0_o[B_PG]);

   p_refused_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && !cr0_o[B_PG] && wr_data[B_PG] &&
       efer_o[B_LME] && !cr4_o[B_PAE]) |=> $stable(cr0_o));

   p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ip_trunc_o |-> !lma_o && !cs64_o && !cr0_o[B_PG]);

   p_keep_global_pg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_keep_global_o |-> cr0_o[B_PG]);

   p_cs64_in_lm_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs64_o |-> lma_o);

   p_no_stray_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !flush_all_o && !flush_keep_global_o && !ip_trunc_o);
endmodule

bind crmode_mgr crmode_chk #(.DATA_W(DATA_W)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .wr_en              (wr_en),
   .wr_sel             (wr_sel),
   .wr_data            (wr_data),
   .cr0_o              (cr0_o),
   .cr4_o              (cr4_o),
   .efer_o             (efer_o),
   .lma_o              (lma_o),
   .cs64_o             (cs64_o),
   .flush_all_o        (flush_all_o),
   .flush_keep_global_o(flush_keep_global_o),
   .ip_trunc_o         (ip_trunc_o)
);

// File: tb/crmode_mgr_test.sv
module crmode_mgr_test;
   localparam int W = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic cs64_wr = 1'b0, cs64_val = 1'b0;
   logic [W-1:0] cr0_o, cr3_o, cr4_o, efer_o;
   logic pe_o, mp_o, em_o, ts_o, lma_o, cs64_o;
   logic flush_all_o, flush_keep_global_o, ip_trunc_o;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model
   logic [W-1:0] m_cr0, m_cr3, m_cr4, m_efer;
   logic m_cs64, m_fa, m_fg, m_tr;

   always #5 clk = ~clk;

   crmode_mgr #(.DATA_W(W), .LONG_MODE_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .cs64_wr(cs64_wr), .cs64_val(cs64_val),
      .cr0_o(cr0_o), .cr3_o(cr3_o), .cr4_o(cr4_o), .efer_o(efer_o),
      .pe_o(pe_o), .mp_o(mp_o), .em_o(em_o), .ts_o(ts_o),
      .lma_o(lma_o), .cs64_o(cs64_o), .flush_all_o(flush_all_o),
      .flush_keep_global_o(flush_keep_global_o), .ip_trunc_o(ip_trunc_o)
   );

   task automatic chk(input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cr0 = 64'h10; m_cr3 = '0; m_cr4 = '0; m_efer = '0;
      m_cs64 = 1'b0; m_fa = 1'b0; m_fg = 1'b0; m_tr = 1'b0;
   endtask

   // expected next state from the requirements, old values used throughout
   task automatic model_step(input logic en, input logic [1:0] sel,
                             input logic [W-1:0] d, input logic cw,
                             input logic cv);
      logic lma_old, enter, leave;
      logic [W-1:0] m0, m4;
      lma_old = m_efer[10];
      m0 = (64'd1 << 31) | (64'd1 << 16) | 64'd1;
      m4 = (64'd1 << 7) | (64'd1 << 5) | (64'd1 << 4);
      m_fa = 1'b0; m_fg = 1'b0; m_tr = 1'b0;
      enter = 1'b0; leave = 1'b0;
      if (en) begin
         case (sel)
            2'd0: begin
               m_fa  = ((d ^ m_cr0) & m0) != '0;
               enter = !m_cr0[31] && d[31] && m_efer[8];
               leave = m_cr0[31] && !d[31] && m_efer[10];
               if (!(enter && !m_cr4[5])) begin
                  m_cr0 = d | 64'h10;
                  if (enter) m_efer[10] = 1'b1;
                  if (leave) m_efer[10] = 1'b0;
               end
            end
            2'd1: begin m_fg = m_cr0[31]; m_cr3 = d; end
            2'd2: begin m_fa = ((d ^ m_cr4) & m4) != '0; m_cr4 = d; end
            default: m_efer = (d & ~(64'd1 << 10)) | (m_efer & (64'd1 << 10));
         endcase
      end
      if (leave) begin m_cs64 = 1'b0; m_tr = 1'b1; end
      else if (cw && lma_old) m_cs64 = cv;
   endtask

   task automatic compare_all();
      chk("R2 cr0", cr0_o, m_cr0);
      chk("R13 cr3", cr3_o, m_cr3);
      chk("R9 cr4", cr4_o, m_cr4);
      chk("R10 efer", efer_o, m_efer);
      chk("R3 flags", {60'd0, ts_o, em_o, mp_o, pe_o}, {60'd0, m_cr0[3:0]});
      chk("R4 lma", {63'd0, lma_o}, {63'd0, m_efer[10]});
      chk("R11 cs64", {63'd0, cs64_o}, {63'd0, m_cs64});
      chk("R7 flush_all", {63'd0, flush_all_o}, {63'd0, m_fa});
      chk("R8 flush_keep_global", {63'd0, flush_keep_global_o}, {63'd0, m_fg});
      chk("R6 ip_trunc", {63'd0, ip_trunc_o}, {63'd0, m_tr});
   endtask

   // called at a falling edge, returns at the next falling edge
   task automatic step(input logic en, input logic [1:0] sel,
                       input logic [W-1:0] d, input logic cw, input logic cv);
      wr_en = en; wr_sel = sel; wr_data = d; cs64_wr = cw; cs64_val = cv;
      model_step(en, sel, d, cw, cv);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; cs64_wr = 1'b0;
      compare_all();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] r;
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 cr0", cr0_o, 64'h10);
      chk("R1 regs", cr3_o | cr4_o | efer_o, '0);
      chk("R1 flags", {54'd0, pe_o, mp_o, em_o, ts_o, lma_o, cs64_o,
                       flush_all_o, flush_keep_global_o, ip_trunc_o, 1'b0}, '0);

      // R2: ET forced on a zero write; R7 no paging bit changed
      step(1'b1, 2'd0, '0, 1'b0, 1'b0);
      chk("R2 et forced", cr0_o, 64'h10);
      // R3: control bits mirrored, PE change flushes (R7)
      step(1'b1, 2'd0, 64'hF, 1'b0, 1'b0);
      chk("R3 pe mirror", {63'd0, pe_o}, 64'd1);
      chk("R7 pe flush", {63'd0, flush_all_o}, 64'd1);
      // R12 pulse gone on idle
      step(1'b0, 2'd0, '0, 1'b0, 1'b0);
      chk("R12 idle", {61'd0, flush_all_o, flush_keep_global_o, ip_trunc_o}, '0);
      // R8 CR3 write with paging off: no flush
      step(1'b1, 2'd1, 64'h1234_5000, 1'b0, 1'b0);
      chk("R8 no flush pg off", {63'd0, flush_keep_global_o}, '0);
      // R10 EFER: LME set, try setting LMA
      step(1'b1, 2'd3, (64'd1 << 8) | (64'd1 << 10), 1'b0, 1'b0);
      chk("R10 lma ignored", {63'd0, efer_o[10]}, '0);
      // R5 entry refused with PAE clear, flush still raised (R7)
      step(1'b1, 2'd0, 64'h8000_0001, 1'b0, 1'b0);
      chk("R5 cr0 kept", cr0_o, 64'h1F);
      chk("R5 no lma", {63'd0, lma_o}, '0);
      // R9 PAE on -> flush; R4 entry
      step(1'b1, 2'd2, 64'h20, 1'b0, 1'b0);
      chk("R9 pae flush", {63'd0, flush_all_o}, 64'd1);
      step(1'b1, 2'd0, 64'h8000_0001, 1'b0, 1'b0);
      chk("R4 lma set", {63'd0, lma_o}, 64'd1);
      // R11 cs64 loads in long mode; R8 CR3 flush with paging on
      step(1'b0, 2'd0, '0, 1'b1, 1'b1);
      chk("R11 cs64 load", {63'd0, cs64_o}, 64'd1);
      step(1'b1, 2'd1, 64'h9000, 1'b0, 1'b0);
      chk("R8 keep-global flush", {63'd0, flush_keep_global_o}, 64'd1);
      // R9 change of non-paging bit: no flush
      step(1'b1, 2'd2, 64'h20 | 64'h200, 1'b0, 1'b0);
      chk("R9 no flush", {63'd0, flush_all_o}, '0);
      // R6 exit long mode
      step(1'b1, 2'd0, 64'h1, 1'b0, 1'b0);
      chk("R6 trunc", {61'd0, ip_trunc_o, lma_o, cs64_o}, 64'b100);
      step(1'b0, 2'd0, '0, 1'b0, 1'b0);
      chk("R12 trunc one cycle", {63'd0, ip_trunc_o}, '0);
      // R11 cs64 refused out of long mode
      step(1'b0, 2'd0, '0, 1'b1, 1'b1);
      chk("R11 cs64 refused", {63'd0, cs64_o}, '0);

      // random phase
      for (int i = 0; i < 1500; i++) begin
         r = {$urandom, $urandom};
         step(($urandom % 4) != 0, 2'($urandom), r,
              ($urandom % 3) == 0, 1'($urandom));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule